// File: doc/BRIEF.md
# Operand-Selectable Integer Multiplier Unit

This unit is the integer multiply stage of a register-file datapath. Each cycle it may accept one operation made of two source words, a five-bit opcode and a destination register index. Two clock edges later it presents a result. The result bundle carries a write-enable, the destination index, a pair flag and two data words. The register file stores `out_lo` at `out_dst`. When the pair flag is high, it also stores `out_hi` at `out_dst + 1`.

The opcode selects one of three kinds of operation, each in a signed or an unsigned form:

- **Half-width product.** One half of each operand is taken; each operand chooses its own half.
- **Truncated full-width product.** Only the lower word of the product is kept.
- **Double-width product.** The full product is split over an even/odd register pair.

An encoding the unit cannot execute is not written. The unit raises an illegal-operation flag for it instead.

Top module: `imul_unit`

## Requirements
- R1: While `rst_n` is low, `out_wen`, `out_illegal`, `out_pair`, `out_dst`, `out_lo` and `out_hi` are all zero, whatever the inputs.
- R2: An operation presented with `in_valid` high at a rising edge produces its result bundle after the second rising edge that follows. A new operation may be presented on every cycle.
- R3: Half mode is selected by `in_op[3:2]` = 00. Bit `in_op[0]` picks the upper (1) or lower (0) half of `in_a`. Bit `in_op[1]` does the same for `in_b`. The DATA_W-bit product goes to `out_lo`, with `out_wen`=1, `out_pair`=0 and `out_hi`=0.
- R4: When `in_op[4]` is 1, every selected half or full operand is sign-extended before multiplying. When it is 0, the operand is zero-extended.
- R5: Low mode is selected by `in_op[3:2]` = 01. `out_lo` holds the lower DATA_W bits of the full-width product, `out_hi`=0 and `out_pair`=0. `in_op[1:0]` has no effect.
- R6: Wide mode is selected by `in_op[3:2]` = 10 with an even `in_dst`. `out_lo` holds the lower DATA_W bits of the product, which go to the even register `out_dst`. `out_hi` holds the upper DATA_W bits, which go to the odd register `out_dst + 1`. `out_pair`=1 and `out_wen`=1.
- R7: Wide mode with an odd `in_dst` gives `out_illegal`=1 for one cycle. In that cycle `out_wen`=0, `out_pair`=0 and both data words are zero.
- R8: The reserved code `in_op[3:2]` = 11 gives `out_illegal`=1 with `out_wen`=0 and zero data.
- R9: A cycle with `in_valid` low produces, two edges later, a bundle with every output zero.
- R10: For every accepted operation, legal or illegal, `out_dst` equals the `in_dst` that was given with it. `out_wen` and `out_illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 5 | Opcode: [4] signed, [3:2] mode, [1] upper half of B, [0] upper half of A |
| in_a | input | DATA_W | First source operand |
| in_b | input | DATA_W | Second source operand |
| in_dst | input | IDX_W | Destination register index |
| out_wen | output | 1 | Register write enable |
| out_illegal | output | 1 | Operation rejected, no write |
| out_pair | output | 1 | Write `out_hi` to `out_dst + 1` as well |
| out_dst | output | IDX_W | Destination index of the result |
| out_lo | output | DATA_W | Result word (even register in wide mode) |
| out_hi | output | DATA_W | Upper product word (odd register), zero otherwise |

## Verification
The bench builds the unit at 8-bit width. It sweeps all 32 opcodes against corner operands: zero, all ones, the sign bit alone, the largest positive value and mixed nibbles. The destination index rotates so that wide mode meets both even and odd targets.

Each corner case targets a specific fault:

- A wrong half select, or sign handling applied to the wrong width, shows up at once in half mode. For example, 0x80 taken as an upper half must become -8 when signed and 8 when unsigned.
- A unit that writes an odd pair, or forgets the reserved code, shows a stray write.
- A unit that drops the upper word in wide mode, or leaks it into the other modes, fails the comparison of `out_hi`.
- Idle cycles are mixed into back-to-back traffic. A stage that fails to clear its valid bit therefore leaves a phantom write, and one that is off by a cycle misaligns every result.

// File: rtl/imul_pkg.sv
package imul_pkg;

  localparam int OP_W = 5;

  typedef enum logic [1:0] {
    MODE_HALF = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_WIDE = 2'b10,
    MODE_RSVD = 2'b11
  } mul_mode_e;

  typedef struct packed {
    logic      is_signed;
    mul_mode_e mode;
    logic      b_upper;
    logic      a_upper;
  } mul_op_t;

endpackage

// File: rtl/imul_operand_sel.sv
module imul_operand_sel #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = DATA_W + 1
) (
  input  logic [DATA_W-1:0]       raw,
  input  logic                    use_upper,
  input  logic                    half_mode,
  input  logic                    is_signed,
  output logic signed [EXT_W-1:0] ext
);
  localparam int HALF_W = DATA_W / 2;

  // Widen one operand to EXT_W bits: choose a half or the whole word, then
  // fill the upper bits with the sign bit (signed) or with zeros (unsigned).
  function automatic logic signed [EXT_W-1:0] widen(
    input logic [DATA_W-1:0] v,
    input logic              upper,
    input logic              half,
    input logic              sgn
  );
    logic [HALF_W-1:0] h;
    logic              fill;
    h = upper ? v[DATA_W-1:HALF_W] : v[HALF_W-1:0];
    if (half) begin
      fill  = sgn & h[HALF_W-1];
      widen = {{(EXT_W-HALF_W){fill}}, h};
    end else begin
      fill  = sgn & v[DATA_W-1];
      widen = {fill, v};
    end
  endfunction

  always_comb ext = widen(raw, use_upper, half_mode, is_signed);

endmodule

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int EXT_W  = DATA_W + 1
) (
  input  mul_op_t                 op,
  input  logic [DATA_W-1:0]       src_a,
  input  logic [DATA_W-1:0]       src_b,
  input  logic [IDX_W-1:0]        dst,
  output logic signed [EXT_W-1:0] ext_a,
  output logic signed [EXT_W-1:0] ext_b,
  output logic                    legal,
  output logic                    wide
);
  logic [DATA_W-1:0]       raw_v [2];
  logic                    up_v  [2];
  logic signed [EXT_W-1:0] ext_v [2];
  logic                    half_mode;

  assign raw_v[0]  = src_a;
  assign raw_v[1]  = src_b;
  assign up_v[0]   = op.a_upper;
  assign up_v[1]   = op.b_upper;
  assign half_mode = (op.mode == MODE_HALF);

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    imul_operand_sel #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_sel (
      .raw       (raw_v[g]),
      .use_upper (up_v[g]),
      .half_mode (half_mode),
      .is_signed (op.is_signed),
      .ext       (ext_v[g])
    );
  end

  assign ext_a = ext_v[0];
  assign ext_b = ext_v[1];

  always_comb begin
    wide = 1'b0;
    unique case (op.mode)
      MODE_HALF: legal = 1'b1;
      MODE_LOW:  legal = 1'b1;
      MODE_WIDE: begin
        legal = ~dst[0];
        wide  = 1'b1;
      end
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/imul_issue_reg.sv
module imul_issue_reg #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int EXT_W  = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    legal,
  input  logic                    wide,
  input  logic [IDX_W-1:0]        dst,
  input  logic signed [EXT_W-1:0] ext_a,
  input  logic signed [EXT_W-1:0] ext_b,
  output logic                    s1_valid,
  output logic                    s1_legal,
  output logic                    s1_wide,
  output logic [IDX_W-1:0]        s1_dst,
  output logic signed [EXT_W-1:0] s1_a,
  output logic signed [EXT_W-1:0] s1_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_legal <= 1'b0;
      s1_wide  <= 1'b0;
      s1_dst   <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_legal <= legal;
      s1_wide  <= wide;
      s1_dst   <= dst;
      s1_a     <= ext_a;
      s1_b     <= ext_b;
    end
  end

endmodule

// File: rtl/imul_product.sv
module imul_product #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int EXT_W  = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic                    s1_legal,
  input  logic                    s1_wide,
  input  logic [IDX_W-1:0]        s1_dst,
  input  logic signed [EXT_W-1:0] s1_a,
  input  logic signed [EXT_W-1:0] s1_b,
  output logic                    out_wen,
  output logic                    out_illegal,
  output logic                    out_pair,
  output logic [IDX_W-1:0]        out_dst,
  output logic [DATA_W-1:0]       out_lo,
  output logic [DATA_W-1:0]       out_hi
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int FULL_W = 2 * EXT_W;

  // Both operands are already extended by one bit, so a signed product of
  // the extended values is right for the signed and the unsigned forms.
  function automatic logic [PROD_W-1:0] mul_ext(
    input logic signed [EXT_W-1:0] a,
    input logic signed [EXT_W-1:0] b
  );
    logic signed [FULL_W-1:0] p;
    p = FULL_W'(a) * FULL_W'(b);
    mul_ext = p[PROD_W-1:0];
  endfunction

  logic [PROD_W-1:0] prod;
  logic              do_write;
  logic              do_pair;

  assign prod     = mul_ext(s1_a, s1_b);
  assign do_write = s1_valid & s1_legal;
  assign do_pair  = do_write & s1_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_pair    <= 1'b0;
      out_dst     <= '0;
      out_lo      <= '0;
      out_hi      <= '0;
    end else begin
      out_wen     <= do_write;
      out_illegal <= s1_valid & ~s1_legal;
      out_pair    <= do_pair;
      out_dst     <= s1_valid ? s1_dst : '0;
      out_lo      <= do_write ? prod[DATA_W-1:0] : '0;
      out_hi      <= do_pair ? prod[PROD_W-1:DATA_W] : '0;
    end
  end

endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IDX_W-1:0]  in_dst,
  output logic              out_wen,
  output logic              out_illegal,
  output logic              out_pair,
  output logic [IDX_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_lo,
  output logic [DATA_W-1:0] out_hi
);
  localparam int EXT_W = DATA_W + 1;

  mul_op_t                 op_f;
  logic signed [EXT_W-1:0] dec_a, dec_b;
  logic                    dec_legal, dec_wide;
  logic                    s1_valid, s1_legal, s1_wide;
  logic [IDX_W-1:0]        s1_dst;
  logic signed [EXT_W-1:0] s1_a, s1_b;

  // Named events for the checker.
  logic evt_accept;
  logic evt_issue_illegal;

  assign op_f              = mul_op_t'(in_op);
  assign evt_accept        = in_valid;
  assign evt_issue_illegal = in_valid & ~dec_legal;

  imul_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_decode (
    .op    (op_f),
    .src_a (in_a),
    .src_b (in_b),
    .dst   (in_dst),
    .ext_a (dec_a),
    .ext_b (dec_b),
    .legal (dec_legal),
    .wide  (dec_wide)
  );

  imul_issue_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .legal    (dec_legal),
    .wide     (dec_wide),
    .dst      (in_dst),
    .ext_a    (dec_a),
    .ext_b    (dec_b),
    .s1_valid (s1_valid),
    .s1_legal (s1_legal),
    .s1_wide  (s1_wide),
    .s1_dst   (s1_dst),
    .s1_a     (s1_a),
    .s1_b     (s1_b)
  );

  imul_product #(.DATA_W(DATA_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_product (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid),
    .s1_legal    (s1_legal),
    .s1_wide     (s1_wide),
    .s1_dst      (s1_dst),
    .s1_a        (s1_a),
    .s1_b        (s1_b),
    .out_wen     (out_wen),
    .out_illegal (out_illegal),
    .out_pair    (out_pair),
    .out_dst     (out_dst),
    .out_lo      (out_lo),
    .out_hi      (out_hi)
  );

endmodule

// File: rtl/imul_checker.sv
module imul_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_accept,
  input logic              evt_issue_illegal,
  input logic [IDX_W-1:0]  in_dst,
  input logic              out_wen,
  input logic              out_illegal,
  input logic              out_pair,
  input logic [IDX_W-1:0]  out_dst,
  input logic [DATA_W-1:0] out_hi
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_wen && !out_illegal && !out_pair);
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> ##2 (out_wen || out_illegal));

  assert_half_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen && !out_pair) |-> (out_hi == '0));

  assert_pair_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_pair |-> (out_wen && !out_dst[0]));

  assert_illegal_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_wen && !out_pair));

  assert_bad_op_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_issue_illegal |-> ##2 out_illegal);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |-> ##2 (!out_wen && !out_illegal));

  assert_dst_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen || out_illegal) |-> (out_dst == $past(in_dst, 2)));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_wen, out_illegal}));

endmodule

bind imul_unit imul_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_imul_checker (
  .clk               (clk),
  .rst_n             (rst_n),
  .evt_accept        (evt_accept),
  .evt_issue_illegal (evt_issue_illegal),
  .in_dst            (in_dst),
  .out_wen           (out_wen),
  .out_illegal       (out_illegal),
  .out_pair          (out_pair),
  .out_dst           (out_dst),
  .out_hi            (out_hi)
);

// File: tb/test_imul_unit.sv
module test_imul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int TH = 4;
  localparam int TI = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [4:0]    in_op = '0;
  logic [TW-1:0] in_a = '0, in_b = '0;
  logic [TI-1:0] in_dst = '0;
  logic          out_wen, out_illegal, out_pair;
  logic [TI-1:0] out_dst;
  logic [TW-1:0] out_lo, out_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  imul_unit #(.DATA_W(TW), .IDX_W(TI)) i_imul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_dst(in_dst),
    .out_wen(out_wen), .out_illegal(out_illegal), .out_pair(out_pair),
    .out_dst(out_dst), .out_lo(out_lo), .out_hi(out_hi)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  bit            e_used [4];
  logic          e_wen  [4];
  logic          e_ill  [4];
  logic          e_pair [4];
  logic [TI-1:0] e_dst  [4];
  logic [TW-1:0] e_lo   [4];
  logic [TW-1:0] e_hi   [4];
  string         e_tag  [4];

  // Keep the low 'bits' bits of v and read them as signed or unsigned.
  function automatic longint fit(input longint v, input int bits, input bit sgn);
    longint r;
    r = v & ((longint'(1) << bits) - 1);
    if (sgn && r[bits-1]) r = r - (longint'(1) << bits);
    return r;
  endfunction

  function automatic logic [TW-1:0] pick(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      4: return 8'h0F;
      5: return 8'hF0;
      6: return 8'hA5;
      default: return 8'h3C;
    endcase
  endfunction

  task automatic compare(input int s);
    checks++;
    if (out_wen !== e_wen[s] || out_illegal !== e_ill[s] || out_pair !== e_pair[s] ||
        out_dst !== e_dst[s] || out_lo !== e_lo[s] || out_hi !== e_hi[s]) begin
      fails++;
      $display("FAIL %s (R2 R10 timing/dst): got wen=%0b ill=%0b pair=%0b dst=%0d lo=%h hi=%h expected wen=%0b ill=%0b pair=%0b dst=%0d lo=%h hi=%h",
               e_tag[s], out_wen, out_illegal, out_pair, out_dst, out_lo, out_hi,
               e_wen[s], e_ill[s], e_pair[s], e_dst[s], e_lo[s], e_hi[s]);
    end
  endtask

  task automatic step(input bit v, input logic [4:0] op, input logic [TW-1:0] a,
                      input logic [TW-1:0] b, input logic [TI-1:0] d);
    int     s, chk, mode;
    bit     sg;
    longint ea, eb, p;
    @(negedge clk);
    chk = (cyc + 2) % 4;
    if (e_used[chk]) compare(chk);
    in_valid = v; in_op = op; in_a = a; in_b = b; in_dst = d;
    s = cyc % 4;
    mode = int'(op[3:2]);
    sg = op[4];
    e_used[s] = 1'b1;
    e_wen[s] = 1'b0; e_ill[s] = 1'b0; e_pair[s] = 1'b0;
    e_lo[s] = '0; e_hi[s] = '0;
    e_dst[s] = v ? d : '0;
    if (!v) begin
      e_tag[s] = "R9 idle";
    end else begin
      case (mode)
        0: begin
          ea = fit(op[0] ? longint'(a >> TH) : longint'(a), TH, sg);
          eb = fit(op[1] ? longint'(b >> TH) : longint'(b), TH, sg);
          p = ea * eb;
          e_wen[s] = 1'b1;
          e_lo[s] = p[TW-1:0];
          e_tag[s] = sg ? "R3 R4 half signed" : "R3 half unsigned";
        end
        1: begin
          ea = fit(longint'(a), TW, sg);
          eb = fit(longint'(b), TW, sg);
          p = ea * eb;
          e_wen[s] = 1'b1;
          e_lo[s] = p[TW-1:0];
          e_tag[s] = sg ? "R4 R5 low signed" : "R5 low unsigned";
        end
        2: begin
          if (d[0]) begin
            e_ill[s] = 1'b1;
            e_tag[s] = "R7 odd pair";
          end else begin
            ea = fit(longint'(a), TW, sg);
            eb = fit(longint'(b), TW, sg);
            p = ea * eb;
            e_wen[s] = 1'b1;
            e_pair[s] = 1'b1;
            e_lo[s] = p[TW-1:0];
            e_hi[s] = p[2*TW-1:TW];
            e_tag[s] = sg ? "R4 R6 wide signed" : "R6 wide unsigned";
          end
        end
        default: begin
          e_ill[s] = 1'b1;
          e_tag[s] = "R8 reserved";
        end
      endcase
    end
    cyc++;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [TI-1:0] dctr;
    dctr = '0;
    // R1: outputs stay quiet under reset even with traffic applied.
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = 5'b01000; in_a = 8'hFF; in_b = 8'hFF; in_dst = 3'd2;
      checks++;
      if (out_wen !== 1'b0 || out_illegal !== 1'b0 || out_pair !== 1'b0 ||
          out_lo !== '0 || out_hi !== '0 || out_dst !== '0) begin
        fails++;
        $display("FAIL R1 reset: got wen=%0b ill=%0b lo=%h expected all zero",
                 out_wen, out_illegal, out_lo);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);
    // Sweep all opcodes over corner operands, back to back with idle gaps.
    for (int op = 0; op < 32; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          step(1'b1, 5'(op), pick(ia), pick(ib), dctr);
          dctr = dctr + 1'b1;
          if ((ia + ib) % 5 == 0) step(1'b0, 5'(op), pick(ib), pick(ia), dctr);
        end
      end
    end
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule